// File: doc/BRIEF.md
# LED Port Output Mode Controller

This block is the output stage of one port of an LED driver that doubles as an I/O expander. An 8-bit port setting picks the mode of the port. Two codes make it a plain GPIO output, driven either low or high. Most of the other codes make it a constant-current sink whose on-time within each PWM period equals the code value. The all-ones code switches the port off. The block keeps its own free-running 8-bit PWM phase counter, which advances on every PWM tick. It reports the pin state on two outputs, `sinkOn` and `pinHiZ`.

A device-wide shutdown flag switches off only the ports in constant-current mode. GPIO ports keep their level while shutdown is asserted and when it is released. During normal running, a new setting waits for the end of the current PWM period so that no period is cut short. During shutdown the block takes the setting at once. A port moved to GPIO therefore shows its new level immediately. A port moved to constant current stays off, and when shutdown is released it joins the shared PWM phase in step with the other ports.

Top module: `ledport_out_stage`

## Requirements
- R1: A setting of 0x00 makes the port a GPIO driven low: `sinkOn`=1 and `pinHiZ`=0.
- R2: A setting of 0x01 makes the port a GPIO driven high: `sinkOn`=0 and `pinHiZ`=0.
- R3: Settings from 0x02 to 0xFE select constant current. Outside shutdown, `sinkOn`=1 while the phase counter is below the setting. At all other phases the pin is released (`pinHiZ`=1). The phase counter is 0 after reset, steps by one on each clock edge that sees `pwmTick`=1, and wraps from 255 to 0.
- R4: A setting of 0xFF switches the port off: `sinkOn`=0 and `pinHiZ`=1.
- R5: While `shutdown`=0, a new `portSetting` takes effect only at a clock edge that sees `pwmTick`=1 while the phase is 255. At every other edge the previous setting is kept.
- R6: While shutdown is in effect, a port in constant-current mode is off: `sinkOn`=0 and `pinHiZ`=1.
- R7: While `shutdown`=1, the setting is taken at every clock edge. A change to 0x00 or 0x01 appears on the outputs after the next edge.
- R8: A port changed to constant current during shutdown stays off until shutdown is released. From the first edge after release it follows the shared phase counter as R3 describes.
- R9: A GPIO port keeps its output unchanged when shutdown is entered and when it is released.
- R10: During reset and after reset the port is off (`sinkOn`=0, `pinHiZ`=1), and shutdown is in effect.
- R11: `sinkOn` and `pinHiZ` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmTick | input | 1 | PWM clock enable; advances the phase counter |
| portSetting | input | 8 | Requested port mode and intensity code |
| shutdown | input | 1 | Device shutdown flag (inverse of the run bit) |
| sinkOn | output | 1 | Current sink / low drive enabled |
| pinHiZ | output | 1 | Pin released (off / high impedance) |

## Verification
Each input is sampled at a clock edge, and the outputs decode only registered state. Any effect of `pwmTick`, `portSetting` or `shutdown` therefore appears exactly one edge later. A setting change made outside shutdown is the exception: it appears one edge after the tick that wraps the phase from 255, which can be hundreds of edges later. The bench drives inputs just after the falling edge and keeps a reference model of phase, applied setting and shutdown, which it advances on each rising edge with the same load rule. It compares the outputs at the following falling edge, so every comparison falls in the cycle where the result is due. Directed sequences walk a whole PWM period up to the wrap. They also enter and leave shutdown with GPIO and constant-current settings.

// File: rtl/ledport_pkg.sv
package ledport_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_HIGH = 2'd1,
    MODE_CC   = 2'd2,
    MODE_OFF  = 2'd3
  } portMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSetting;   // capture portSetting into the applied register
    logic advancePhase;  // step the PWM phase counter
    logic forceLow;      // GPIO low drive
    logic gateOff;       // pin released regardless of phase
    logic pwmEnable;     // sink follows phase compare
  } ctrlStrobe_t;

endpackage

// File: rtl/ledport_ctrl.sv
module ledport_ctrl
  import ledport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          pwmTick,
  input  logic          shutdown,
  input  logic          periodEnd,
  input  logic [W-1:0]  appliedSetting,
  input  logic          shutdownQ,
  output portMode_t     mode,
  output ctrlStrobe_t   strobe
);
  localparam logic [W-1:0] LOW_CODE  = '0;
  localparam logic [W-1:0] HIGH_CODE = W'(1);
  localparam logic [W-1:0] OFF_CODE  = '1;

  // Mode decode of the applied setting
  always_comb begin
    if (appliedSetting == LOW_CODE)       mode = MODE_LOW;
    else if (appliedSetting == HIGH_CODE) mode = MODE_HIGH;
    else if (appliedSetting == OFF_CODE)  mode = MODE_OFF;
    else                                  mode = MODE_CC;
  end

  always_comb begin
    strobe = '0;
    strobe.advancePhase = pwmTick;
    // shutdown: take settings at once; running: only at the period wrap
    strobe.loadSetting  = shutdown | (pwmTick & periodEnd);
    unique case (mode)
      MODE_LOW:  strobe.forceLow = 1'b1;
      MODE_HIGH: strobe.forceLow = 1'b0;
      MODE_OFF:  strobe.gateOff  = 1'b1;
      MODE_CC: begin
        strobe.gateOff   = shutdownQ;
        strobe.pwmEnable = ~shutdownQ;
      end
      default:   strobe.gateOff  = 1'b1;
    endcase
  end

endmodule

// File: rtl/ledport_datapath.sv
module ledport_datapath
  import ledport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  portSetting,
  input  logic          shutdown,
  input  ctrlStrobe_t   strobe,
  output logic          periodEnd,
  output logic [W-1:0]  appliedSetting,
  output logic          shutdownQ,
  output logic          sinkOn,
  output logic          pinHiZ
);
  localparam logic [W-1:0] PHASE_LAST = '1;
  localparam logic [W-1:0] OFF_CODE   = '1;

  logic [W-1:0] phase;
  logic         dutyActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase          <= '0;
      appliedSetting <= OFF_CODE;
      shutdownQ      <= 1'b1;
    end else begin
      shutdownQ <= shutdown;
      if (strobe.advancePhase) phase <= phase + W'(1);
      if (strobe.loadSetting)  appliedSetting <= portSetting;
    end
  end

  assign periodEnd  = (phase == PHASE_LAST);
  assign dutyActive = (phase < appliedSetting);

  always_comb begin
    sinkOn = strobe.forceLow | (strobe.pwmEnable & dutyActive);
    pinHiZ = strobe.gateOff  | (strobe.pwmEnable & ~dutyActive);
  end

  // Phase steps by one on each advance strobe (R3)
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.advancePhase) |-> phase == $past(phase) + W'(1));

  // Outputs never both asserted (R11)
  p_no_conflict_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(sinkOn && pinHiZ));

endmodule

// File: rtl/ledport_out_stage.sv
module ledport_out_stage
  import ledport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwmTick,
  input  logic [W-1:0]  portSetting,
  input  logic          shutdown,
  output logic          sinkOn,
  output logic          pinHiZ
);
  portMode_t    mode;
  ctrlStrobe_t  strobe;
  logic         periodEnd;
  logic [W-1:0] appliedSetting;
  logic         shutdownQ;

  ledport_ctrl #(.W(W)) uCtrl (
    .pwmTick        (pwmTick),
    .shutdown       (shutdown),
    .periodEnd      (periodEnd),
    .appliedSetting (appliedSetting),
    .shutdownQ      (shutdownQ),
    .mode           (mode),
    .strobe         (strobe)
  );

  ledport_datapath #(.W(W)) uData (
    .clk            (clk),
    .rstN           (rstN),
    .portSetting    (portSetting),
    .shutdown       (shutdown),
    .strobe         (strobe),
    .periodEnd      (periodEnd),
    .appliedSetting (appliedSetting),
    .shutdownQ      (shutdownQ),
    .sinkOn         (sinkOn),
    .pinHiZ         (pinHiZ)
  );

  localparam logic [W-1:0] OFF_CODE = '1;

  // Constant-current setting under shutdown leaves the pin released (R6, R8)
  p_sd_cc_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(shutdown) && $past(portSetting) > W'(1)
      && $past(portSetting) != OFF_CODE |-> pinHiZ && !sinkOn);

  // GPIO low chosen in shutdown shows one edge later (R7, R1)
  p_sd_gpio_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(shutdown) && $past(portSetting) == '0 |-> sinkOn && !pinHiZ);

  // GPIO high chosen in shutdown shows one edge later (R7, R2)
  p_sd_gpio_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(shutdown) && $past(portSetting) == W'(1) |-> !sinkOn && !pinHiZ);

endmodule

// File: tb/sim_ledport_out_stage.sv
module sim_ledport_out_stage;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwmTick = 1'b0;
  logic [7:0] portSetting = 8'hFF;
  logic       shutdown = 1'b1;
  logic       sinkOn, pinHiZ;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] mPhase = 8'd0;
  logic [7:0] mSet = 8'hFF;
  logic       mSd = 1'b1;

  always #4 clk = ~clk;

  ledport_out_stage u0 (
    .clk(clk), .rstN(rstN), .pwmTick(pwmTick), .portSetting(portSetting),
    .shutdown(shutdown), .sinkOn(sinkOn), .pinHiZ(pinHiZ)
  );

  function automatic logic expSink(logic [7:0] s, logic sd, logic [7:0] ph);
    if (s == 8'h00) return 1'b1;
    if (s == 8'h01 || s == 8'hFF || sd) return 1'b0;
    return ph < s;
  endfunction

  function automatic logic expHiZ(logic [7:0] s, logic sd, logic [7:0] ph);
    if (s == 8'h00 || s == 8'h01) return 1'b0;
    if (s == 8'hFF || sd) return 1'b1;
    return !(ph < s);
  endfunction

  function automatic string reqFor(logic [7:0] s, logic sd);
    if (s == 8'h00) return "R1";
    if (s == 8'h01) return "R2";
    if (s == 8'hFF) return "R4";
    if (sd) return "R6";
    return "R3";
  endfunction

  task automatic checkOut(string tag);
    logic es, eh;
    string t;
    es = expSink(mSet, mSd, mPhase);
    eh = expHiZ(mSet, mSd, mPhase);
    t = (tag == "") ? reqFor(mSet, mSd) : tag;
    checks++;
    if (sinkOn !== es || pinHiZ !== eh) begin
      errors++;
      $display("FAIL %s: sinkOn/pinHiZ=%b%b expected %b%b (set=%h sd=%b phase=%0d)",
               t, sinkOn, pinHiZ, es, eh, mSet, mSd, mPhase);
    end
    checks++;
    if (sinkOn === 1'b1 && pinHiZ === 1'b1) begin
      errors++;
      $display("FAIL R11: sinkOn/pinHiZ=11 expected not both set");
    end
  endtask

  // drive after negedge, model at posedge, compare at next negedge
  task automatic step(logic tk, logic [7:0] s, logic sd, string tag);
    pwmTick = tk; portSetting = s; shutdown = sd;
    @(posedge clk);
    if (sd || (tk && mPhase == 8'hFF)) mSet = s;
    mSd = sd;
    if (tk) mPhase = mPhase + 8'd1;
    @(negedge clk);
    checkOut(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R10");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R10");

    // leave shutdown with 0xFF applied; request 0x00 mid-period: held (R5)
    step(1'b0, 8'hFF, 1'b0, "R4");
    for (int i = 0; i < 255; i++) step(1'b1, 8'h00, 1'b0, "R5");
    step(1'b1, 8'h00, 1'b0, "R5");   // wrap: now GPIO low
    checkOut("R1");

    // request CC 0x80; applied at next wrap, then full period (R3)
    for (int i = 0; i < 255; i++) step(1'b1, 8'h80, 1'b0, "R5");
    for (int i = 0; i < 300; i++) step(1'b1, 8'h80, 1'b0, "R3");
    step(1'b0, 8'h80, 1'b0, "R3");

    // shutdown turns CC off (R6)
    step(1'b1, 8'h80, 1'b1, "R6");
    step(1'b1, 8'h80, 1'b1, "R6");
    // CC -> GPIO high in shutdown appears at once (R7)
    step(1'b1, 8'h01, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b1, "R7");
    // GPIO -> CC in shutdown stays off (R8)
    step(1'b1, 8'hC0, 1'b1, "R8");
    step(1'b1, 8'hC0, 1'b1, "R8");
    // release: follows shared phase right away (R8)
    for (int i = 0; i < 260; i++) step(1'b1, 8'hC0, 1'b0, "R8");

    // GPIO low through shutdown entry and exit (R9)
    step(1'b0, 8'h00, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b0, "R9");
    step(1'b1, 8'h00, 1'b1, "R9");
    step(1'b1, 8'h00, 1'b0, "R9");
    step(1'b0, 8'h01, 1'b1, "R2");
    step(1'b1, 8'h01, 1'b0, "R9");
    step(1'b1, 8'h01, 1'b1, "R9");
    step(1'b1, 8'h01, 1'b0, "R9");
    step(1'b0, 8'hFF, 1'b1, "R4");

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 12000; i++) begin
      logic [7:0] s;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: s = 8'h00;
        1: s = 8'h01;
        2: s = 8'hFF;
        3: s = 8'h02;
        4: s = 8'hFE;
        default: s = 8'($urandom_range(0, 255));
      endcase
      step(($urandom_range(0, 3) != 0), s, ($urandom_range(0, 15) == 0), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule